// File: doc/BRIEF.md
# Distributed-arithmetic inner product unit

The unit forms the dot product of four fixed signed coefficients with four signed input samples and uses no multiplier. The caller presents all four samples on one packed bus together with a one-cycle start strobe. The unit keeps a local copy of the samples. On each cycle it collects one bit from every sample, at the same bit position in each. Those bits form an index into a small constant table, and each table entry holds the sum of the coefficients whose index bit is set. A shift-accumulator adds one table word per cycle and shifts its running total right by one position. The bit positions are taken from the least significant upward. The word for the sign position comes last and is subtracted, which is done by inverting it and setting the carry-in. After all the bit positions the finished total appears on the result port, and done pulses for one cycle.

The table is built from the coefficient parameter when the design is elaborated. The accumulator is wide enough that no combination of samples and coefficients can overflow it.

Top module: `da_dot`

## Requirements
- R1: While rst_n is low, and after it is released until the first result, done is 0 and result is 0.
- R2: Sample i occupies x_in[i*10 +: 10] as a 10-bit two's-complement integer (bit 9 weighs -512). The coefficients are c0=-2048, c1=2047, c2=1234 and c3=-777. Each coefficient is stored as a 12-bit signed field in COEFS[i*12 +: 12]. At each done, result equals the exact sum of c_i*x_i as a 25-bit two's-complement number. The samples used are those captured at the accepted start.
- R3: A start is accepted at a rising clock edge when the unit is idle. done then goes high exactly 10 clock edges later, and not before.
- R4: done is high for exactly one cycle per accepted start.
- R5: result changes only in the cycle in which done is high, and it holds its value between done pulses.
- R6: A start at a clock edge while the unit is busy is ignored. It does not restart the unit, it does not change the result being formed, and it produces no extra done.
- R7: The sign bit position is subtracted. Inputs at -512 (only bit 9 set) and the largest-magnitude mixes of -512 and +511 give exact results, with no overflow.
- R8: A start given at the first edge after done (the unit is idle again) is accepted, and it produces its own result 10 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; samples x_in when idle |
| x_in | input | 40 | Four packed 10-bit signed samples |
| result | output | 25 | Signed inner product of the last completed run |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A start accepted at edge E gives done and the new result after edge E+10. The bench drives inputs on falling edges. After each accepted start it samples done and result on the ten falling edges that follow. It requires done to be low on the first nine and high, with the expected value, on the tenth. Starts given while the unit is busy are placed inside that window, and the bench still expects the original value on the original schedule. After that it expects no further pulse and an unchanged result.

// File: rtl/da_dot.sv
module da_dot #(
  parameter int NUM_IN = 4,
  parameter int IN_W   = 10,
  parameter int COEF_W = 12,
  parameter logic [NUM_IN*COEF_W-1:0] COEFS = 48'hCF7_4D2_7FF_800,
  localparam int ADDR_W = NUM_IN,
  localparam int ROM_N  = 2**NUM_IN,
  localparam int PS_W   = COEF_W + $clog2(NUM_IN) + 1,
  localparam int ACC_W  = PS_W + IN_W,
  localparam int CNT_W  = $clog2(IN_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NUM_IN*IN_W-1:0] x_in,
  output logic [ACC_W-1:0]       result,
  output logic                   done
);

  function automatic logic signed [PS_W-1:0] entry(logic [ADDR_W-1:0] a);
    logic signed [PS_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (a[i])
        s = s + {{(PS_W-COEF_W){COEFS[i*COEF_W+COEF_W-1]}}, COEFS[i*COEF_W +: COEF_W]};
    return s;
  endfunction

  logic signed [PS_W-1:0] rom [ROM_N];
  for (genvar a = 0; a < ROM_N; a++) begin : g_rom
    assign rom[a] = entry(ADDR_W'(a));
  end

  logic [IN_W-1:0]  x_sh [NUM_IN];
  logic [ADDR_W-1:0] addr;
  for (genvar i = 0; i < NUM_IN; i++) begin : g_slice
    assign addr[i] = x_sh[i][0];
  end

  logic                    busy;
  logic [CNT_W-1:0]        cnt;
  logic signed [ACC_W-1:0] acc, acc_sh, addend, acc_nxt;
  logic signed [PS_W-1:0]  word;
  logic                    neg;

  assign neg     = (cnt == CNT_W'(IN_W-1));
  assign word    = neg ? ~rom[addr] : rom[addr];
  assign addend  = {{IN_W{word[PS_W-1]}}, word};
  assign acc_sh  = acc >>> 1;
  assign acc_nxt = acc_sh + (addend <<< (IN_W-1)) + (ACC_W'(neg) <<< (IN_W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      result <= '0;
      for (int i = 0; i < NUM_IN; i++) x_sh[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          acc  <= '0;
          for (int i = 0; i < NUM_IN; i++) x_sh[i] <= x_in[i*IN_W +: IN_W];
        end
      end else begin
        acc <= acc_nxt;
        for (int i = 0; i < NUM_IN; i++) x_sh[i] <= x_sh[i] >> 1;
        if (neg) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= acc_nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/da_dot_chk.sv
module da_dot_chk #(
  parameter int NUM_IN = 4,
  parameter int IN_W   = 10,
  parameter int COEF_W = 12,
  parameter logic [NUM_IN*COEF_W-1:0] COEFS = 48'hCF7_4D2_7FF_800,
  localparam int ACC_W = COEF_W + $clog2(NUM_IN) + 1 + IN_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [NUM_IN*IN_W-1:0] x_in,
  input logic [ACC_W-1:0]       result,
  input logic                   done
);
  logic                   cb;
  logic [31:0]            cc;
  logic [NUM_IN*IN_W-1:0] cap;
  logic signed [ACC_W-1:0] exp_v;
  logic                   last;

  assign last = cb && (cc == 32'(IN_W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb  <= 1'b0;
      cc  <= '0;
      cap <= '0;
    end else if (!cb) begin
      if (start) begin
        cb  <= 1'b1;
        cc  <= '0;
        cap <= x_in;
      end
    end else if (last) begin
      cb <= 1'b0;
    end else begin
      cc <= cc + 1;
    end
  end

  always_comb begin
    logic signed [ACC_W-1:0] xe, ce;
    exp_v = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      xe = ACC_W'($signed(cap[i*IN_W +: IN_W]));
      ce = ACC_W'($signed(COEFS[i*COEF_W +: COEF_W]));
      exp_v = exp_v + xe * ce;
    end
  end

  a_r1_quiet_reset: assert property (@(posedge clk) !rst_n |=> (!done && result == '0));
  a_r3_due:         assert property (@(posedge clk) disable iff (!rst_n) last |=> done);
  a_r3_not_early:   assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(last));
  a_r4_done_pulse:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
  a_r2_value:       assert property (@(posedge clk) disable iff (!rst_n) done |-> ($signed(result) == exp_v));
endmodule

bind da_dot da_dot_chk #(
  .NUM_IN(NUM_IN), .IN_W(IN_W), .COEF_W(COEF_W), .COEFS(COEFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .result(result), .done(done)
);

// File: tb/da_dot_tb_top.sv
module da_dot_tb_top;
  localparam int B = 10;
  localparam longint C [4] = '{-2048, 2047, 1234, -777};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [39:0] x_in = '0;
  logic [24:0] result;
  logic        done;
  int          n_chk = 0, n_bad = 0;
  logic [24:0] held;

  always #5 clk = ~clk;

  da_dot dut_i (.clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
                .result(result), .done(done));

  function automatic longint ref_dot(logic [39:0] v);
    longint s = 0;
    for (int i = 0; i < 4; i++) s += C[i] * longint'($signed(v[i*10 +: 10]));
    return s;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // called at a falling edge; returns at the falling edge after done
  task automatic run_vec(logic [39:0] v, string tag, bit busy_start);
    longint e = ref_dot(v);
    bit early = 0;
    x_in  = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= B; k++) begin
      @(negedge clk);
      if (k < B) begin
        if (done) early = 1;
        if (busy_start && k == 3) begin
          x_in  = ~v;
          start = 1'b1;
        end else begin
          start = 1'b0;
        end
      end
    end
    check(!early && done, {tag, " R3 done timing"}, longint'(done), 1);
    check(longint'($signed(result)) == e, {tag, " R2 value"}, longint'($signed(result)), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!done && result == '0, "R1 reset state", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && result == '0, "R1 after release", longint'(result), 0);

    run_vec(40'h0, "zero", 0);
    run_vec({4{10'h001}}, "ones", 0);
    run_vec({4{10'h200}}, "R7 all -512", 0);
    run_vec({10'h200, 10'h1FF, 10'h1FF, 10'h200}, "R7 extreme mix", 0);
    run_vec({10'h1FF, 10'h200, 10'h200, 10'h1FF}, "R7 extreme mix2", 0);
    run_vec({4{10'h1FF}}, "all +511", 0);
    run_vec({4{10'h3FF}}, "all -1", 0);

    @(negedge clk);
    check(!done, "R4 single pulse", longint'(done), 0);

    run_vec({10'h155, 10'h2AA, 10'h0F0, 10'h30F}, "R6 busy start", 1);
    held = result;
    begin
      bit extra = 0;
      for (int k = 0; k < B + 3; k++) begin
        @(negedge clk);
        if (done || result != held) extra = 1;
      end
      check(!extra, "R6 no restart / R5 hold", longint'(result), longint'(held));
    end

    run_vec({10'h123, 10'h321, 10'h2EE, 10'h011}, "R8 first", 0);
    run_vec({10'h200, 10'h0AB, 10'h3CD, 10'h1FF}, "R8 back-to-back", 0);

    for (int n = 0; n < 60; n++) begin
      logic [39:0] v;
      v = {$urandom, $urandom};
      run_vec(v, "R2 random", (n % 7) == 3);
      if ((n % 5) == 0) begin
        held = result;
        @(negedge clk);
        check(!done && result == held, "R5 hold", longint'(result), longint'(held));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule